// File: doc/BRIEF.md
# Floating-point IEEE exception cause prioritizer

This block sits next to a floating-point unit and runs when an arithmetic operation signals an IEEE-754 exception. On an exception strobe it takes the status-register control bits, the trap-enable mask and the current-exception bits. From them it forms the updated floating-point status word and raises a trap request with the fixed IEEE-exception trap type.

The floating-point trap type field (bits 16:14 of the status word) is forced to the IEEE-exception code 1. The enabled overflow, underflow and inexact causes are then reduced to one cause before the trap is taken. Overflow ranks above underflow, and underflow ranks above inexact. Invalid-operation and divide-by-zero causes pass through unchanged. When none of the three ranked causes is enabled, the exception bits are kept exactly as they arrived.

All results are registered. They appear one clock after the strobe and hold until the next strobe. The trap request is a single-cycle pulse.

Top module: `fpx_cause_prio`

## Requirements
- R1: While reset is held and in the first cycle after it, every output is zero and no trap is requested.
- R2: One cycle after a strobe, `ftt_o` is 3'd1, and bits 16:14 of `fsr_o` are 3'b001 whatever those bits held in `fsr_ctrl_i`.
- R3: The exception field bit order is [4]=invalid, [3]=overflow, [2]=underflow, [1]=divide-by-zero, [0]=inexact. If overflow is set in both `cexc_i` and `tem_i`, then after the strobe `cexc_o[3]` is 1 and `cexc_o[2]` and `cexc_o[0]` are 0.
- R4: If underflow is enabled and set, and overflow is not both enabled and set, then after the strobe `cexc_o[2]` is 1 and `cexc_o[3]` and `cexc_o[0]` are 0.
- R5: If only inexact is both enabled and set among bits 3, 2 and 0, then after the strobe `cexc_o[0]` is 1 and `cexc_o[3]` and `cexc_o[2]` are 0.
- R6: If no bit among 3, 2 and 0 is set in both `cexc_i` and `tem_i`, then after the strobe `cexc_o` equals `cexc_i`.
- R7: After any strobe, `cexc_o[4]` and `cexc_o[1]` equal the `cexc_i` bits sampled with the strobe.
- R8: `trap_req_o` is high for exactly the one cycle after each strobe, and `trap_type_o` is 9'h021 in that cycle.
- R9: After a strobe, `fsr_o` equals `fsr_ctrl_i` with bits 16:14 replaced by 3'b001, ORed with `tem_i` shifted left by 23, ORed with `cexc_o`.
- R10: In a cycle without a strobe, input changes are ignored. `ftt_o`, `cexc_o` and `fsr_o` keep their values, and `trap_req_o` falls to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| exc_strobe_i | input | 1 | An operation has signalled an IEEE exception |
| fsr_ctrl_i | input | FSR_W | Status-register control bits |
| tem_i | input | 5 | Trap-enable mask, same bit order as the exception field |
| cexc_i | input | 5 | Current exception bits |
| ftt_o | output | 3 | Updated floating-point trap type field |
| cexc_o | output | 5 | Prioritized exception bits |
| fsr_o | output | FSR_W | Full updated status word |
| trap_req_o | output | 1 | One-cycle trap request |
| trap_type_o | output | 9 | Trap type; 9'h021 while a trap is requested |

## Verification
Every pair of exception bits and enable mask (1024 combinations) is applied under two control words. The first control word is all zero. The second has the trap-type field and unrelated bits set, which separates an overwritten FTT field from an ORed one.

Combinations with overflow enabled tell the overflow-wins case apart from the lower ranks. Combinations where causes are set but disabled show that only enabled causes count, and that an empty match leaves the bits untouched. Between strobes the inputs are inverted, to show that results hold and the trap pulse ends.

// File: rtl/fpx_pkg.sv
package fpx_pkg;
    localparam int CAUSE_W  = 5;
    localparam int FTT_W    = 3;
    localparam int FTT_LSB  = 14;
    localparam int TEM_LSB  = 23;

    localparam int B_INV    = 4;
    localparam int B_OVF    = 3;
    localparam int B_UNF    = 2;
    localparam int B_DVZ    = 1;
    localparam int B_INX    = 0;

    localparam logic [FTT_W-1:0] FTT_IEEE = 3'd1;

    localparam logic [CAUSE_W-1:0] RANKED_MASK =
        CAUSE_W'((1 << B_OVF) | (1 << B_UNF) | (1 << B_INX));

    typedef logic [CAUSE_W-1:0] cause_t;
endpackage

// File: rtl/fpx_cause_pick.sv
module fpx_cause_pick
    import fpx_pkg::*;
#(
    parameter int RANKS = 3,
    parameter int ORDER [RANKS] = '{B_OVF, B_UNF, B_INX}
) (
    input  cause_t cexc_i,
    input  cause_t tem_i,
    output cause_t cexc_o,
    output logic   hit_o
);
    cause_t live;
    cause_t keep;
    logic   found;

    assign live = cexc_i & tem_i & RANKED_MASK;

    always_comb begin
        keep  = '0;
        found = 1'b0;
        for (int r = 0; r < RANKS; r++) begin
            if (!found && live[ORDER[r]]) begin
                keep[ORDER[r]] = 1'b1;
                found          = 1'b1;
            end
        end
    end

    assign hit_o  = found;
    assign cexc_o = found ? ((cexc_i & ~RANKED_MASK) | keep) : cexc_i;
endmodule

// File: rtl/fpx_fsr_pack.sv
module fpx_fsr_pack
    import fpx_pkg::*;
#(
    parameter int FSR_W = 32
) (
    input  logic [FSR_W-1:0] ctrl_i,
    input  logic [FTT_W-1:0] ftt_i,
    input  cause_t           tem_i,
    input  cause_t           cexc_i,
    output logic [FSR_W-1:0] fsr_o
);
    localparam logic [FSR_W-1:0] FTT_FIELD =
        FSR_W'(((1 << FTT_W) - 1) << FTT_LSB);

    logic [FSR_W-1:0] ftt_w;
    logic [FSR_W-1:0] tem_w;
    logic [FSR_W-1:0] cexc_w;

    assign ftt_w  = FSR_W'(ftt_i)  << FTT_LSB;
    assign tem_w  = FSR_W'(tem_i)  << TEM_LSB;
    assign cexc_w = FSR_W'(cexc_i);
    assign fsr_o  = (ctrl_i & ~FTT_FIELD) | ftt_w | tem_w | cexc_w;
endmodule

// File: rtl/fpx_cause_prio.sv
module fpx_cause_prio
    import fpx_pkg::*;
#(
    parameter int               FSR_W     = 32,
    parameter int               TT_W      = 9,
    parameter logic [TT_W-1:0]  TRAP_TYPE = 9'h021
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              exc_strobe_i,
    input  logic [FSR_W-1:0]  fsr_ctrl_i,
    input  logic [4:0]        tem_i,
    input  logic [4:0]        cexc_i,
    output logic [2:0]        ftt_o,
    output logic [4:0]        cexc_o,
    output logic [FSR_W-1:0]  fsr_o,
    output logic              trap_req_o,
    output logic [TT_W-1:0]   trap_type_o
);
    typedef struct packed {
        logic              trap;
        logic [FTT_W-1:0]  ftt;
        cause_t            cexc;
        logic [FSR_W-1:0]  fsr;
    } state_t;

    state_t st_d, st_q;

    cause_t           picked;
    logic             picked_hit;
    logic [FSR_W-1:0] packed_fsr;

    fpx_cause_pick u_pick (
        .cexc_i (cexc_i),
        .tem_i  (tem_i),
        .cexc_o (picked),
        .hit_o  (picked_hit)
    );

    fpx_fsr_pack #(.FSR_W(FSR_W)) u_pack (
        .ctrl_i (fsr_ctrl_i),
        .ftt_i  (FTT_IEEE),
        .tem_i  (tem_i),
        .cexc_i (picked),
        .fsr_o  (packed_fsr)
    );

    always_comb begin
        st_d      = st_q;
        st_d.trap = 1'b0;
        if (exc_strobe_i) begin
            st_d.trap = 1'b1;
            st_d.ftt  = FTT_IEEE;
            st_d.cexc = picked;
            st_d.fsr  = packed_fsr;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign ftt_o       = st_q.ftt;
    assign cexc_o      = st_q.cexc;
    assign fsr_o       = st_q.fsr;
    assign trap_req_o  = st_q.trap;
    assign trap_type_o = st_q.trap ? TRAP_TYPE : '0;
endmodule

// File: rtl/fpx_cause_prio_chk.sv
module fpx_cause_prio_chk #(
    parameter int FSR_W = 32,
    parameter int TT_W  = 9
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             exc_strobe_i,
    input logic [4:0]       tem_i,
    input logic [4:0]       cexc_i,
    input logic [2:0]       ftt_o,
    input logic [4:0]       cexc_o,
    input logic [FSR_W-1:0] fsr_o,
    input logic             trap_req_o,
    input logic [TT_W-1:0]  trap_type_o
);
    logic [4:0] live;
    assign live = cexc_i & tem_i & 5'b01101;

    assert_ftt_code_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        exc_strobe_i |=> (ftt_o == 3'd1) && (fsr_o[16:14] == 3'b001));

    assert_single_cause_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (exc_strobe_i && live != 5'b0) |=> ($countones(cexc_o & 5'b01101) == 1));

    assert_ovf_wins_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (exc_strobe_i && live[3]) |=> (cexc_o[3] && !cexc_o[2] && !cexc_o[0]));

    assert_unchanged_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (exc_strobe_i && live == 5'b0) |=> (cexc_o == $past(cexc_i)));

    assert_passthru_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        exc_strobe_i |=> (cexc_o[4] == $past(cexc_i[4])) && (cexc_o[1] == $past(cexc_i[1])));

    assert_trap_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        exc_strobe_i |=> (trap_req_o && trap_type_o == 9'h021));

    assert_no_trap_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !exc_strobe_i |=> !trap_req_o);

    assert_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!exc_strobe_i && $past(rst_ni)) |=> ($stable(cexc_o) && $stable(fsr_o) && $stable(ftt_o)));
endmodule

bind fpx_cause_prio fpx_cause_prio_chk #(.FSR_W(FSR_W), .TT_W(TT_W)) chk_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .exc_strobe_i (exc_strobe_i),
    .tem_i        (tem_i),
    .cexc_i       (cexc_i),
    .ftt_o        (ftt_o),
    .cexc_o       (cexc_o),
    .fsr_o        (fsr_o),
    .trap_req_o   (trap_req_o),
    .trap_type_o  (trap_type_o)
);

// File: tb/fpx_cause_prio_tb_top.sv
`timescale 1ns/1ps
module fpx_cause_prio_tb_top;
    localparam int FSR_W = 32;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             strobe = 1'b0;
    logic [FSR_W-1:0] ctrl = '0;
    logic [4:0]       tem = '0;
    logic [4:0]       cexc = '0;
    logic [2:0]       ftt_o;
    logic [4:0]       cexc_o;
    logic [FSR_W-1:0] fsr_o;
    logic             trap_o;
    logic [8:0]       tt_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    fpx_cause_prio #(.FSR_W(FSR_W)) dut_i (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .exc_strobe_i (strobe),
        .fsr_ctrl_i   (ctrl),
        .tem_i        (tem),
        .cexc_i       (cexc),
        .ftt_o        (ftt_o),
        .cexc_o       (cexc_o),
        .fsr_o        (fsr_o),
        .trap_req_o   (trap_o),
        .trap_type_o  (tt_o)
    );

    task automatic check(input bit ok, input string req,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [4:0] model_cexc(input logic [4:0] c, input logic [4:0] t);
        logic [4:0] m;
        int v;
        m = c & t & 5'b01101;
        v = int'(m);
        if (v == 0) return c;
        if (v >= 8) return (c & 5'b10010) | 5'b01000;
        if (v >= 4) return (c & 5'b10010) | 5'b00100;
        return (c & 5'b10010) | 5'b00001;
    endfunction

    initial begin
        logic [FSR_W-1:0] ctrl_set [2];
        ctrl_set[0] = 32'h0000_0000;
        ctrl_set[1] = 32'h8001_C3E0;

        repeat (3) @(negedge clk);
        check(ftt_o == 0 && cexc_o == 0 && fsr_o == 0 && !trap_o && tt_o == 0,
              "R1 reset", {trap_o, fsr_o}, 64'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!trap_o && fsr_o == 0 && cexc_o == 0, "R1 after release", {trap_o, fsr_o}, 64'h0);

        for (int k = 0; k < 2; k++) begin
            for (int i = 0; i < 1024; i++) begin
                logic [4:0] c, t, ec, m;
                logic [FSR_W-1:0] ef;
                c = i[4:0];
                t = i[9:5];
                m = c & t & 5'b01101;
                ec = model_cexc(c, t);
                ef = (ctrl_set[k] & ~32'h0001_C000) | 32'h0000_4000
                     | (FSR_W'(t) << 23) | FSR_W'(ec);
                ctrl = ctrl_set[k];
                cexc = c;
                tem = t;
                strobe = 1'b1;
                @(negedge clk);
                check(ftt_o == 3'd1 && fsr_o[16:14] == 3'b001, "R2 ftt code",
                      {ftt_o, fsr_o[16:14]}, 64'h9);
                if (m[3])
                    check(cexc_o == ec, "R3 overflow wins", cexc_o, ec);
                else if (m[2])
                    check(cexc_o == ec, "R4 underflow over inexact", cexc_o, ec);
                else if (m[0])
                    check(cexc_o == ec, "R5 inexact alone", cexc_o, ec);
                else
                    check(cexc_o == c, "R6 no enabled cause", cexc_o, c);
                check(cexc_o[4] == c[4] && cexc_o[1] == c[1], "R7 invalid/divzero pass",
                      {cexc_o[4], cexc_o[1]}, {c[4], c[1]});
                check(trap_o && tt_o == 9'h021, "R8 trap pulse", {trap_o, tt_o}, 64'h221);
                check(fsr_o == ef, "R9 fsr compose", fsr_o, ef);
                strobe = 1'b0;
                cexc = ~c;
                tem = ~t;
                ctrl = ~ctrl_set[k];
                @(negedge clk);
                check(!trap_o, "R8 single cycle", trap_o, 0);
                check(cexc_o == ec && fsr_o == ef && ftt_o == 3'd1, "R10 hold idle",
                      fsr_o, ef);
            end
        end
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (200000) @(posedge clk);
                errors++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule